// File: doc/BRIEF.md
# UART Fractional Baud Rate Generator

This block turns a fast clock into the 16x-oversampling enable that paces a UART's transmit and receive shifters. A 16-bit whole-number divisor, formed from a high byte and a low byte, sets a base period of clock cycles. A fractional stage then stretches chosen base periods so that the average rate comes out finer than any whole divisor could give. The fractional stage is set by a multiplier value M (1 to 15) and an add value A (0 to M-1). On average one tick occurs every divisor × (M + A) / M clocks, so the baud rate is f_clk / (16 × divisor × (1 + A/M)).

All five setting inputs are sampled only on a single-cycle load strobe. Between loads the pins may change freely, because the running rate comes from held copies. A load checks the fractional pair. If M is zero, or A is not strictly below M, a config error flag is raised and the block falls back to whole-number division. Every load also restarts the divisor counter and the fractional accumulator, so a new rate always begins from a clean phase. There is no data stream through the block. Every pin is a plain control or status signal, and `tick_o` is a one-cycle enable with no handshake and no back-pressure.

Top module: `frac_baud_gen`

## Requirements
- R1: While `rst_n` is low, `tick_o` and `config_error` are 0. After reset the held settings are divisor 1, M = 1 and A = 0, so from the first clock edge after reset release `tick_o` is high on every cycle.
- R2: The divisor is 256 × `div_hi` + `div_lo`, and a value of 0 is used as 1. With A = 0, successive ticks are exactly divisor clocks apart.
- R3: A 4-bit accumulator starts at 0 on every load. When a tick period starts, s = acc + A. If A ≠ 0 and s ≥ M, acc becomes s − M and this period lasts 2 × divisor clocks. Otherwise acc becomes s and the period lasts divisor clocks. The accumulator always stays below M.
- R4: Over a long run the number of ticks in W clocks is within one of W × M / (divisor × (M + A)).
- R5: A load with `mul_in` = 0, or with `divadd_in` ≥ `mul_in`, sets `config_error` to 1 from the cycle after the load. A load with valid values clears it. `config_error` changes in no other cycle.
- R6: While `config_error` is 1, ticks are exactly divisor clocks apart, as if A = 0.
- R7: Changes on `div_hi`, `div_lo`, `mul_in` and `divadd_in` without a load have no effect on the tick pattern or on `config_error`.
- R8: On the cycle after a load, `tick_o` is 0. If the load is sampled at clock edge E, the first tick follows edge E + P, where P is the first period given by R3 with the accumulator at 0.
- R9: When the divisor is 2 or more, `tick_o` is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock the ticks are derived from |
| rst_n | input | 1 | Active-low synchronous reset |
| div_hi | input | 8 | Upper byte of the whole-number divisor |
| div_lo | input | 8 | Lower byte of the whole-number divisor |
| mul_in | input | 4 | Fractional multiplier M, valid range 1 to 15 |
| divadd_in | input | 4 | Fractional add value A, valid when below M |
| load | input | 1 | One-cycle strobe that samples all settings and restarts the phase |
| tick_o | output | 1 | One-cycle enable at 16 times the baud rate |
| config_error | output | 1 | High while the held fractional pair is invalid |

## Verification
Two events can fall in the same cycle: a load and the terminal count that would raise a tick. A load can also land on the last cycle of a stretched period. The sweep issues each new load while the previous setting is still running, at whatever phase that setting has reached. With divisor 1 every cycle is a terminal count, so the collision is certain there. The bench judges the outcome from the tick pattern alone: `tick_o` must be low on the cycle after the load, and every later tick must land on the exact clock predicted from the new setting with the accumulator restarted at zero.

// File: rtl/frac_baud_pkg.sv
package frac_baud_pkg;

  // Phase within one tick period: base divisor period, or the extra
  // divisor period inserted when the fractional accumulator wraps.
  typedef enum logic {
    SEG_BASE    = 1'b0,
    SEG_STRETCH = 1'b1
  } seg_e;

endpackage

// File: rtl/frac_baud_cfg.sv
module frac_baud_cfg #(
  parameter int BYTE_W = 8,
  parameter int FRAC_W = 4,
  localparam int DIV_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BYTE_W-1:0] div_hi,
  input  logic [BYTE_W-1:0] div_lo,
  input  logic [FRAC_W-1:0] mul_in,
  input  logic [FRAC_W-1:0] add_in,
  output logic [DIV_W-1:0]  div_eff,
  output logic [FRAC_W-1:0] mul_eff,
  output logic [FRAC_W-1:0] add_eff,
  output logic              cfg_err
);

  logic [DIV_W-1:0] div_raw;
  logic             pair_bad;

  assign div_raw  = {div_hi, div_lo};
  assign pair_bad = (mul_in == '0) || (add_in >= mul_in);

  // Held copies: pins are looked at only on the load strobe.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_eff <= DIV_W'(1);
      mul_eff <= FRAC_W'(1);
      add_eff <= '0;
      cfg_err <= 1'b0;
    end else if (load) begin
      div_eff <= (div_raw == '0) ? DIV_W'(1) : div_raw;
      cfg_err <= pair_bad;
      mul_eff <= pair_bad ? FRAC_W'(1) : mul_in;
      add_eff <= pair_bad ? '0 : add_in;
    end
  end

endmodule

// File: rtl/frac_baud_divider.sv
module frac_baud_divider #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [DIV_W-1:0] div_eff,
  output logic [DIV_W-1:0] cnt_q,
  output logic             period_end
);

  assign period_end = (cnt_q == (div_eff - DIV_W'(1)));

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      cnt_q <= '0;
    end else if (period_end) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + DIV_W'(1);
    end
  end

endmodule

// File: rtl/frac_baud_accum.sv
module frac_baud_accum
  import frac_baud_pkg::*;
#(
  parameter int FRAC_W = 4,
  localparam int SUM_W = FRAC_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              period_end,
  input  logic [FRAC_W-1:0] mul_eff,
  input  logic [FRAC_W-1:0] add_eff,
  output logic [FRAC_W-1:0] acc_q,
  output logic              fire
);

  seg_e             seg_q;
  logic [SUM_W-1:0] sum;
  logic [SUM_W-1:0] wrapped;
  logic             carry;

  assign sum     = {1'b0, acc_q} + {1'b0, add_eff};
  assign wrapped = sum - {1'b0, mul_eff};
  assign carry   = (add_eff != '0) && (sum >= {1'b0, mul_eff});
  // A tick ends the period unless this base segment is to be stretched.
  assign fire    = period_end && ((seg_q == SEG_STRETCH) || !carry);

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      acc_q <= '0;
      seg_q <= SEG_BASE;
    end else if (period_end) begin
      if (seg_q == SEG_STRETCH) begin
        seg_q <= SEG_BASE;
      end else if (carry) begin
        acc_q <= wrapped[FRAC_W-1:0];
        seg_q <= SEG_STRETCH;
      end else begin
        acc_q <= sum[FRAC_W-1:0];
      end
    end
  end

endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen #(
  parameter int BYTE_W = 8,
  parameter int FRAC_W = 4,
  localparam int DIV_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] div_hi,
  input  logic [BYTE_W-1:0] div_lo,
  input  logic [FRAC_W-1:0] mul_in,
  input  logic [FRAC_W-1:0] divadd_in,
  input  logic              load,
  output logic              tick_o,
  output logic              config_error
);

  logic [DIV_W-1:0]  div_eff;
  logic [FRAC_W-1:0] mul_eff;
  logic [FRAC_W-1:0] add_eff;
  logic [DIV_W-1:0]  cnt_q;
  logic [FRAC_W-1:0] acc_q;
  logic              period_end;
  logic              fire;

  frac_baud_cfg #(.BYTE_W(BYTE_W), .FRAC_W(FRAC_W)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .div_hi  (div_hi),
    .div_lo  (div_lo),
    .mul_in  (mul_in),
    .add_in  (divadd_in),
    .div_eff (div_eff),
    .mul_eff (mul_eff),
    .add_eff (add_eff),
    .cfg_err (config_error)
  );

  frac_baud_divider #(.DIV_W(DIV_W)) u_div (
    .clk        (clk),
    .rst_n      (rst_n),
    .restart    (load),
    .div_eff    (div_eff),
    .cnt_q      (cnt_q),
    .period_end (period_end)
  );

  frac_baud_accum #(.FRAC_W(FRAC_W)) u_acc (
    .clk        (clk),
    .rst_n      (rst_n),
    .restart    (load),
    .period_end (period_end),
    .mul_eff    (mul_eff),
    .add_eff    (add_eff),
    .acc_q      (acc_q),
    .fire       (fire)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || load) begin
      tick_o <= 1'b0;
    end else begin
      tick_o <= fire;
    end
  end

endmodule

// File: rtl/frac_baud_chk.sv
module frac_baud_chk #(
  parameter int DIV_W  = 16,
  parameter int FRAC_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              load,
  input logic              tick_o,
  input logic              config_error,
  input logic [DIV_W-1:0]  div_eff,
  input logic [FRAC_W-1:0] mul_eff,
  input logic [FRAC_W-1:0] add_eff,
  input logic [DIV_W-1:0]  cnt_q,
  input logic [FRAC_W-1:0] acc_q
);

  AST_DIV_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    div_eff != '0);  // R2

  AST_CNT_BELOW_DIV: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < div_eff);  // R2

  AST_ACC_BELOW_MUL: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q < mul_eff);  // R3

  AST_ERR_FALLBACK: assert property (@(posedge clk) disable iff (!rst_n)
    config_error |-> (add_eff == '0));  // R6

  AST_ERR_ONLY_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(config_error));  // R5

  AST_LOAD_CLEARS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !tick_o);  // R8

  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && (div_eff != DIV_W'(1))) |=> !tick_o);  // R9

endmodule

bind frac_baud_gen frac_baud_chk #(.DIV_W(DIV_W), .FRAC_W(FRAC_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .load         (load),
  .tick_o       (tick_o),
  .config_error (config_error),
  .div_eff      (div_eff),
  .mul_eff      (mul_eff),
  .add_eff      (add_eff),
  .cnt_q        (cnt_q),
  .acc_q        (acc_q)
);

// File: tb/frac_baud_gen_bench.sv
`timescale 1ns/1ps
module frac_baud_gen_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] div_hi = '0;
  logic [7:0] div_lo = '0;
  logic [3:0] mul_in = '0;
  logic [3:0] divadd_in = '0;
  logic       load = 1'b0;
  logic       tick_o;
  logic       config_error;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  frac_baud_gen u_frac_baud_gen (
    .clk          (clk),
    .rst_n        (rst_n),
    .div_hi       (div_hi),
    .div_lo       (div_lo),
    .mul_in       (mul_in),
    .divadd_in    (divadd_in),
    .load         (load),
    .tick_o       (tick_o),
    .config_error (config_error)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Load a setting at the next edge, then scramble the pins (R7).
  // Returns at the falling edge just after the load edge.
  task automatic do_load(input int hi, input int lo, input int m, input int a);
    @(negedge clk);
    div_hi = 8'(hi); div_lo = 8'(lo); mul_in = 4'(m); divadd_in = 4'(a);
    load = 1'b1;
    @(negedge clk);
    load = 1'b0;
    div_hi = 8'hA5; div_lo = 8'h3C; mul_in = 4'd0; divadd_in = 4'd15;
  endtask

  // Load and follow ntick ticks cycle by cycle against the R3 rule.
  task automatic run_cfg(input int hi, input int lo, input int m, input int a,
                         input int ntick, input string tag);
    int  dv, em, ea, acc, nxt, k, seen, s;
    bit  bad;
    dv = 256 * hi + lo;
    if (dv == 0) dv = 1;
    bad = (m == 0) || (a >= m);
    em = bad ? 1 : m;
    ea = bad ? 0 : a;
    acc = 0;
    do_load(hi, lo, m, a);
    chk(config_error == bad, "R5 config_error after load", config_error, bad);
    chk(tick_o == 1'b0, "R8 tick low after load", tick_o, 0);
    s = acc + ea;
    if (ea != 0 && s >= em) begin acc = s - em; nxt = 2 * dv; end
    else begin acc = s; nxt = dv; end
    k = 0; seen = 0;
    while (seen < ntick) begin
      @(negedge clk);
      k++;
      if (k == nxt) begin
        chk(tick_o == 1'b1, {tag, " tick expected"}, tick_o, 1);
        seen++;
        s = acc + ea;
        if (ea != 0 && s >= em) begin acc = s - em; nxt = k + 2 * dv; end
        else begin acc = s; nxt = k + dv; end
      end else begin
        chk(tick_o == 1'b0, {tag, " no tick"}, tick_o, 0);
      end
    end
    chk(config_error == bad, "R7 config_error held without load", config_error, bad);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1: reset state, then default divisor 1 ticks every cycle
    repeat (3) @(negedge clk);
    chk(tick_o == 1'b0, "R1 tick in reset", tick_o, 0);
    chk(config_error == 1'b0, "R1 error in reset", config_error, 0);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(tick_o == 1'b1, "R1 default tick every cycle", tick_o, 1);
    end

    // R3/R8: sweep every valid pair, small divisors, loads at any phase
    for (int m = 1; m <= 15; m++) begin
      for (int a = 0; a < m; a++) begin
        run_cfg(0, 1 + ((m + a) % 3), m, a, 2 * m + 1, "R3 sweep");
      end
    end

    // R5/R6: invalid pairs fall back to integer division
    run_cfg(0, 3, 0, 0, 5, "R6 mul zero");
    run_cfg(0, 3, 5, 5, 5, "R6 add equal mul");
    run_cfg(0, 3, 3, 9, 5, "R6 add above mul");
    run_cfg(0, 2, 15, 15, 5, "R6 both max");
    run_cfg(0, 4, 9, 2, 12, "R5 valid after invalid");

    // R2: zero divisor acts as 1, high byte weighs 256
    run_cfg(0, 0, 4, 1, 12, "R2 zero divisor");
    run_cfg(1, 2, 2, 1, 4, "R2 high byte");
    run_cfg(0, 7, 1, 0, 6, "R2 integer only");

    // R9: back-to-back divisor 2 stays single-cycle (checked every cycle)
    run_cfg(0, 2, 15, 14, 30, "R9 dense stretch");

    // R4: long-run average
    begin
      longint cnt, w, dv, m, a, lhs, tol;
      dv = 5; m = 13; a = 6; w = 20000; cnt = 0;
      do_load(0, 5, 13, 6);
      for (int i = 0; i < 20000; i++) begin
        @(negedge clk);
        if (tick_o) cnt++;
      end
      lhs = cnt * dv * (m + a) - w * m;
      if (lhs < 0) lhs = -lhs;
      tol = dv * (m + a);
      chk(lhs <= tol, "R4 average tick count", cnt, (w * m) / (dv * (m + a)));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule